// File: doc/BRIEF.md
# Packet Slot Manager

This block keeps track of which slots in a shared on-chip packet memory are taken. The memory is split into `NUM_SLOTS` numbered slots that serve both directions. A host drives it through a small register bus. It can ask for a transmit slot, give back the oldest received packet, give back a slot by number, or wipe the whole memory. Each command holds a busy flag for a fixed number of cycles, and its effect lands on the cycle that busy drops. When an allocation finishes, the block sets an interrupt flag and fills in a result register. That register says either which slot was granted or that none was available.

The receive side has its own request input. Each request takes the lowest free slot and returns its number the next cycle. That number is also appended to a received-packet queue, which the host later drains with the remove command. A request that finds no free slot, or a full queue, is reported as dropped. A free-slot count in the upper byte of an information register tells the host whether any space is left.

The packet payload storage, framing and line interface sit outside this block.

Top module: `pkt_slot_mgr`

## Requirements
- R1: After reset, busy reads 0, the interrupt flag is 0, the result register reads 0, the queue is empty and the free count equals NUM_SLOTS.
- R2: Command register is address 0 and its opcode field is bits 2:0. The opcodes are 1 allocate, 2 remove queue head, 3 release by number, 4 clear all. A write of a valid opcode while idle makes bit 0 of address 0, and the busy port, read 1 for exactly CMD_CYCLES cycles. Opcodes 0 and 5 to 7 are ignored. Any command write while busy is ignored.
- R3: A successful allocation picks the lowest-numbered free slot and marks it used. The result register (address 2) then reads bit 7 = 0 and bits 5:0 = slot number.
- R4: Every allocation completion, pass or fail, sets the interrupt flag (address 3, bit 0). Writing 1 to that bit clears it; writing 0 leaves it alone.
- R5: An allocation with no free slot leaves the slots unchanged. The result register then reads bit 7 = 1 and bits 5:0 = 0.
- R6: Release by number frees the slot held in the packet-number register (address 1, bits 5:0) as sampled when the command starts. A number of NUM_SLOTS or above changes nothing.
- R7: Clear all frees every slot and empties the received-packet queue.
- R8: A one-cycle rx_req takes the lowest slot that is free after any command completing in the same cycle. On the next cycle, rx_ack pulses with that number on rx_pnum. The number is appended to the queue tail.
- R9: When rx_req finds no free slot or a full queue, rx_drop pulses the next cycle. In that case nothing is allocated and nothing is queued.
- R10: The remove command frees the slot at the queue head and pops it. On an empty queue it has no effect.
- R11: Address 4 reads the free slot count in bits 15:8 and 0 in bits 7:0. The count is zero exactly when every slot is used.
- R12: Address 5 reads the queue length in bits 15:8 and the head slot number in bits 5:0 (0 when empty). Address 1 reads back the packet-number register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| busy | output | 1 | A command is executing |
| alloc_irq | output | 1 | Allocation-complete interrupt flag |
| rx_req | input | 1 | Receive side requests a slot |
| rx_ack | output | 1 | Receive request granted (one cycle) |
| rx_pnum | output | 6 | Slot number granted to the receive side |
| rx_drop | output | 1 | Receive request dropped (one cycle) |

## Verification
A corrupted occupancy bit shows up one of two ways. The free count at address 4 becomes wrong on the very next read. Or a later allocation or receive grant returns a slot number the model does not expect. The bench checks every grant against a reference occupancy map after each operation, so such a fault surfaces within one operation. A queue pointer fault appears as a wrong head or length at address 5, and also when a remove frees the wrong slot. A sequencing fault changes the busy window length, which the bench counts cycle by cycle on every command.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    localparam int PNUM_W   = 6;
    localparam int REG_W    = 16;
    localparam int FAIL_BIT = 7;

    typedef logic [PNUM_W-1:0] pnum_t;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_ALLOC_TX  = 3'd1,
        OP_POP_RX    = 3'd2,
        OP_FREE_NUM  = 3'd3,
        OP_CLEAR_ALL = 3'd4
    } cmd_op_e;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_PNUM   = 3'd1,
        RA_RESULT = 3'd2,
        RA_IRQ    = 3'd3,
        RA_FREE   = 3'd4,
        RA_RXQ    = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic  failed;
        pnum_t pnum;
    } alloc_result_t;

    function automatic logic op_is_valid(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd4);
    endfunction

endpackage

// File: rtl/pbm_cmd_seq.sv
module pbm_cmd_seq
    import pbm_pkg::*;
#(
    parameter int CMD_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_cmd,
    input  cmd_op_e op_in,
    output logic    start,
    output logic    busy,
    output logic    done,
    output cmd_op_e op_q
);

    localparam int CW = $clog2(CMD_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign start = wr_cmd && !busy && op_is_valid(op_in);
    assign done  = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            op_q  <= OP_NONE;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CMD_CYCLES - 1);
            op_q  <= op_in;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);  // R2

    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_cmd));  // R2

endmodule

// File: rtl/pbm_slot_map.sv
module pbm_slot_map
    import pbm_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clear_all,
    input  logic                             cmd_alloc,
    input  logic                             cmd_free,
    input  logic [$clog2(NUM_SLOTS)-1:0]     cmd_free_idx,
    input  logic                             rx_alloc,
    output logic                             cmd_ok,
    output logic [$clog2(NUM_SLOTS)-1:0]     cmd_idx,
    output logic                             rx_ok,
    output logic [$clog2(NUM_SLOTS)-1:0]     rx_idx,
    output logic [$clog2(NUM_SLOTS+1)-1:0]   free_cnt
);

    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0] used_q;
    logic [NUM_SLOTS-1:0] after_cmd;
    logic [NUM_SLOTS-1:0] used_d;

    // lowest free slot in the current map, for the host command
    always_comb begin
        cmd_ok  = 1'b0;
        cmd_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                cmd_ok  = 1'b1;
                cmd_idx = IDX_W'(i);
            end
        end
    end

    // map once the completing command has acted
    always_comb begin
        after_cmd = used_q;
        if (clear_all) after_cmd = '0;
        if (cmd_free) after_cmd[cmd_free_idx] = 1'b0;
        if (cmd_alloc && cmd_ok) after_cmd[cmd_idx] = 1'b1;
    end

    // receive side picks from what the command left behind
    always_comb begin
        rx_ok  = 1'b0;
        rx_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!after_cmd[i]) begin
                rx_ok  = 1'b1;
                rx_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        used_d = after_cmd;
        if (rx_alloc && rx_ok) used_d[rx_idx] = 1'b1;
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            free_cnt = free_cnt + CNT_W'(!used_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) used_q <= '0;
        else     used_q <= used_d;
    end

    AST_RX_MARKED: assert property (@(posedge clk) disable iff (rst)
        (rx_alloc && rx_ok) |=> used_q[$past(rx_idx)]);  // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clear_all && !rx_alloc) |=> (free_cnt == CNT_W'(NUM_SLOTS)));  // R7

endmodule

// File: rtl/pbm_rx_fifo.sv
module pbm_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[clear ? '0 : wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= push_ok ? nxt('0) : '0;
            count  <= push_ok ? CW'(1) : '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));  // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));  // R8

endmodule

// File: rtl/pkt_slot_mgr.sv
module pkt_slot_mgr
    import pbm_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int CMD_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        busy,
    output logic        alloc_irq,
    input  logic        rx_req,
    output logic        rx_ack,
    output logic [5:0]  rx_pnum,
    output logic        rx_drop
);

    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    logic          start;
    logic          done;
    cmd_op_e       op_q;
    pnum_t         pnum_reg;
    pnum_t         arg_q;
    alloc_result_t result_q;

    logic             do_alloc, do_pop, do_free_num, do_clear;
    logic             cmd_free;
    logic [IDX_W-1:0] cmd_free_idx;
    logic             cmd_ok, rx_ok, rx_take;
    logic [IDX_W-1:0] cmd_idx, rx_idx;
    logic [CNT_W-1:0] free_cnt;

    logic [PNUM_W-1:0]            q_head;
    logic [$clog2(NUM_SLOTS+1)-1:0] q_count;
    logic                         q_full, q_empty;

    logic wr_ctrl, wr_pnum, wr_irq;
    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_pnum = reg_wr && (reg_addr == RA_PNUM);
    assign wr_irq  = reg_wr && (reg_addr == RA_IRQ);

    pbm_cmd_seq #(.CMD_CYCLES(CMD_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .wr_cmd (wr_ctrl),
        .op_in  (cmd_op_e'(reg_wdata[2:0])),
        .start  (start),
        .busy   (busy),
        .done   (done),
        .op_q   (op_q)
    );

    assign do_alloc    = done && (op_q == OP_ALLOC_TX);
    assign do_pop      = done && (op_q == OP_POP_RX) && !q_empty;
    assign do_free_num = done && (op_q == OP_FREE_NUM) && (32'(arg_q) < NUM_SLOTS);
    assign do_clear    = done && (op_q == OP_CLEAR_ALL);

    assign cmd_free     = do_pop || do_free_num;
    assign cmd_free_idx = do_pop ? q_head[IDX_W-1:0] : arg_q[IDX_W-1:0];

    pbm_slot_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk          (clk),
        .rst          (rst),
        .clear_all    (do_clear),
        .cmd_alloc    (do_alloc),
        .cmd_free     (cmd_free),
        .cmd_free_idx (cmd_free_idx),
        .rx_alloc     (rx_take),
        .cmd_ok       (cmd_ok),
        .cmd_idx      (cmd_idx),
        .rx_ok        (rx_ok),
        .rx_idx       (rx_idx),
        .free_cnt     (free_cnt)
    );

    assign rx_take = rx_req && rx_ok && !q_full;

    pbm_rx_fifo #(.DEPTH(NUM_SLOTS), .W(PNUM_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clear (do_clear),
        .push  (rx_take),
        .din   (PNUM_W'(rx_idx)),
        .pop   (do_pop),
        .head  (q_head),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pnum_reg  <= '0;
            arg_q     <= '0;
            result_q  <= '0;
            alloc_irq <= 1'b0;
            rx_ack    <= 1'b0;
            rx_pnum   <= '0;
            rx_drop   <= 1'b0;
        end else begin
            if (wr_pnum) pnum_reg <= reg_wdata[PNUM_W-1:0];
            if (start)   arg_q    <= pnum_reg;
            if (do_alloc) begin
                result_q.failed <= !cmd_ok;
                result_q.pnum   <= cmd_ok ? PNUM_W'(cmd_idx) : '0;
            end
            if (do_alloc)                 alloc_irq <= 1'b1;
            else if (wr_irq && reg_wdata[0]) alloc_irq <= 1'b0;
            rx_ack  <= rx_take;
            rx_drop <= rx_req && !rx_take;
            if (rx_take) rx_pnum <= PNUM_W'(rx_idx);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata = {15'b0, busy};
            RA_PNUM:   reg_rdata = {10'b0, pnum_reg};
            RA_RESULT: reg_rdata = {8'b0, result_q.failed, 1'b0, result_q.pnum};
            RA_IRQ:    reg_rdata = {15'b0, alloc_irq};
            RA_FREE:   reg_rdata = {8'(free_cnt), 8'b0};
            RA_RXQ:    reg_rdata = {8'(q_count), 2'b0, q_empty ? 6'd0 : q_head};
            default:   reg_rdata = '0;
        endcase
    end

    AST_IRQ_ON_ALLOC: assert property (@(posedge clk) disable iff (rst)
        do_alloc |=> alloc_irq);  // R4

    AST_FAIL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (do_alloc && free_cnt != '0) |=> !result_q.failed);  // R5

    AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rx_ack && rx_drop));  // R9

endmodule

// File: tb/pkt_slot_mgr_tb.sv
module pkt_slot_mgr_tb;

    localparam int NS  = 32;
    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy, alloc_irq, rx_req = 1'b0, rx_ack, rx_drop;
    logic [5:0]  rx_pnum;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit [NS-1:0] m_used;
    int          m_q[$];
    bit          m_fail;
    int          m_rpnum;
    bit          m_irq;
    int          m_pnum;

    always #10 clk = ~clk;

    pkt_slot_mgr #(.NUM_SLOTS(NS), .CMD_CYCLES(CYC)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .alloc_irq(alloc_irq), .rx_req(rx_req), .rx_ack(rx_ack),
        .rx_pnum(rx_pnum), .rx_drop(rx_drop)
    );

    function automatic int first_free(input bit [NS-1:0] u);
        for (int i = 0; i < NS; i++) if (!u[i]) return i;
        return -1;
    endfunction

    function automatic int popfree(input bit [NS-1:0] u);
        int n = 0;
        for (int i = 0; i < NS; i++) if (!u[i]) n++;
        return n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic m_alloc();
        int ff = first_free(m_used);
        if (ff >= 0) begin m_fail = 0; m_rpnum = ff; m_used[ff] = 1; end
        else begin m_fail = 1; m_rpnum = 0; end
        m_irq = 1;
    endtask

    task automatic m_apply(input int op, input int arg);
        case (op)
            1: m_alloc();
            2: if (m_q.size() > 0) begin int h = m_q.pop_front(); m_used[h] = 0; end
            3: if (arg < NS) m_used[arg] = 0;
            4: begin m_used = '0; m_q.delete(); end
            default: ;
        endcase
    endtask

    task automatic do_cmd(input int op);
        logic [15:0] d;
        int arg = m_pnum;
        wr(3'd0, 16'(op));
        if (op >= 1 && op <= 4) begin
            for (int i = 0; i < CYC; i++) begin
                rd(3'd0, d);
                chk("R2 busy window", {d[0], busy}, 2'b11);
                @(negedge clk);
            end
            m_apply(op, arg);
        end
        rd(3'd0, d);
        chk("R2 busy clear", {d[0], busy}, 2'b00);
    endtask

    task automatic m_rx(output bit ok, output int n);
        int ff = first_free(m_used);
        ok = (ff >= 0) && (m_q.size() < NS);
        n = ff;
        if (ok) begin m_used[ff] = 1; m_q.push_back(ff); end
    endtask

    task automatic do_rx();
        bit ok; int n;
        rx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0;
        m_rx(ok, n);
        if (ok) begin
            chk("R8 rx_ack", {rx_ack, rx_drop}, 2'b10);
            chk("R8 rx_pnum", rx_pnum, n);
        end else begin
            chk("R9 rx_drop", {rx_ack, rx_drop}, 2'b01);
        end
    endtask

    task automatic check_all();
        logic [15:0] d;
        int exp_head;
        rd(3'd2, d); chk("R3/R5 result", d, {8'b0, m_fail, 1'b0, 6'(m_rpnum)});
        rd(3'd3, d); chk("R4 irq", d, {15'b0, m_irq});
        chk("R4 irq port", alloc_irq, m_irq);
        rd(3'd4, d); chk("R11 free info", d, {8'(popfree(m_used)), 8'b0});
        exp_head = (m_q.size() > 0) ? m_q[0] : 0;
        rd(3'd5, d); chk("R12 rx queue", d, {8'(m_q.size()), 2'b0, 6'(exp_head)});
        rd(3'd1, d); chk("R12 pnum readback", d, 16'(m_pnum));
    endtask

    task automatic set_pnum(input int n);
        wr(3'd1, 16'(n));
        m_pnum = n;
    endtask

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED_1234));
        m_used = '0; m_fail = 0; m_rpnum = 0; m_irq = 0; m_pnum = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, d); chk("R1 busy after reset", d, 0);
        check_all();

        // R3 R4: three allocations give 0,1,2
        for (int k = 0; k < 3; k++) begin do_cmd(1); check_all(); end
        // R4: writing 0 keeps flag, writing 1 clears
        wr(3'd3, 16'h0000); check_all();
        wr(3'd3, 16'h0001); m_irq = 0; check_all();

        // R6: release slot 1 then reallocate it
        set_pnum(1); do_cmd(3); check_all();
        do_cmd(1); chk("R3 reuse lowest", m_rpnum, 1); check_all();
        // R6: out-of-range number has no effect
        set_pnum(40); do_cmd(3); check_all();

        // R2: command while busy is ignored
        wr(3'd0, 16'd1);
        wr(3'd0, 16'd4);
        repeat (CYC - 1) @(negedge clk);
        m_alloc();
        check_all();
        // R2: invalid opcodes do nothing
        do_cmd(6); do_cmd(0); check_all();

        // R7 clear, then R8 fill via receive side
        do_cmd(4); check_all();
        for (int k = 0; k < NS; k++) do_rx();
        check_all();
        rd(3'd4, d); chk("R11 zero when full", d[15:8], 0);
        do_rx();                      // R9 drop
        check_all();
        do_cmd(1);                    // R5 fail
        chk("R5 fail flag", m_fail, 1);
        check_all();
        // R10 pop head then allocate it
        do_cmd(2); check_all();
        do_cmd(1); chk("R10 freed head reused", m_rpnum, 0); check_all();
        // R7 then R10 on empty queue
        do_cmd(4); check_all();
        do_cmd(2); check_all();

        // R8: rx request on the cycle an allocation completes
        wr(3'd0, 16'd1);
        repeat (CYC - 1) @(negedge clk);
        m_alloc();
        do_rx();
        chk("R8 rx after same-cycle alloc", rx_pnum, 1);
        check_all();

        // random mix
        for (int it = 0; it < 500; it++) begin
            int r = $urandom % 100;
            if (r < 32)      do_rx();
            else if (r < 50) do_cmd(1);
            else if (r < 64) do_cmd(2);
            else if (r < 76) begin set_pnum($urandom % 40); do_cmd(3); end
            else if (r < 80) do_cmd(4);
            else if (r < 88) begin
                bit b = 1'($urandom);
                wr(3'd3, {15'b0, b});
                if (b) m_irq = 0;
            end
            else if (r < 94) do_cmd(($urandom % 2) ? 0 : 5 + ($urandom % 3));
            else set_pnum($urandom % 64);
            check_all();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule